// File: doc/BRIEF.md
# Keyboard and Mouse Wake Isolation

This block sits between the clock and data lines of a PS/2-style keyboard and mouse and an internal keyboard controller. Under software control it cuts either device's clock and data off from the controller: a cut line is shown to the controller as idle high, so the controller sees no transitions. The raw data lines still feed the wake logic, so a keystroke or mouse movement can wake the system while the controller is kept quiet.

Four wake sources each set a sticky status bit: a rising keyboard interrupt, a rising mouse interrupt, and a falling edge on either data line. The interrupt sources work only while main supply is present. The data-edge sources also work on standby power alone. A power-management event output is raised when a status bit, its own enable and a global enable are all set. The block also turns the controller's raw interrupts into the keyboard and mouse interrupt outputs. Each output takes either the latched form or the raw-AND-latched form. The block also holds a controller reset bit that software must clear itself.

Software reaches four 8-bit registers through a simple write/read port. The isolation bits, status, enables and data-line synchronizers are in the standby domain and are cleared only by the standby reset. The latch-form bits, the controller reset bit and the interrupt latches are cleared by either reset.

Top module: `kbm_wake_iso`

## Requirements
- R1: While control register (address 0) bit 6 is 1, ms_clk_ctl and ms_dat_ctl are 1. While it is 0 they follow ms_clk_in and ms_dat_in.
- R2: While control register bit 5 is 1, kb_clk_ctl and kb_dat_ctl are 1. While it is 0 they follow kb_clk_in and kb_dat_in.
- R3: A falling edge on kb_dat_in sets status (address 2) bit 3. A falling edge on ms_dat_in sets status bit 4. This happens whether or not the line is isolated, on the third rising clock edge after the input changes.
- R4: A rising edge of kc_kb_irq sets status bit 0, and a rising edge of kc_ms_irq sets status bit 1. This happens only while main_pwr is 1.
- R5: A data-line edge sets its status bit only while main_pwr or stby_only is 1.
- R6: Status bits are sticky. Writing 1 to a status bit clears it. If an event and a clearing write fall in the same cycle, the bit stays set.
- R7: pme is 1 exactly when enable register (address 3) bit 7 is 1 and some status bit in positions 0, 1, 3 or 4 has its enable bit, in the same position of address 3, set to 1.
- R8: Control bit 3 (keyboard) and bit 4 (mouse) pick the interrupt form. With the bit at 1, the output is the interrupt latch. With the bit at 0, the output is the raw controller interrupt ANDed with the latch.
- R9: An interrupt latch is set on a rising edge of the raw interrupt. It is cleared by its host read strobe (host_rd_kb or host_rd_ms). If both happen in the same cycle, the latch is set.
- R10: The isolation bits, status and enables are cleared only by rst_stby_n. A main reset (rst_main_n low) clears the latch-form bits, the controller reset bit and the latches. Register writes are ignored while rst_main_n is low.
- R11: kc_rst follows global configuration register (address 1) bit 6. It stays set until software writes 0 to that bit.
- R12: After reset all registers read 0, pme, kb_irq and ms_irq are 0, and the controller lines follow the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_stby_n | input | 1 | Standby-power reset, active low, clears everything |
| rst_main_n | input | 1 | Main-supply reset, active low |
| main_pwr | input | 1 | Main supply present |
| stby_only | input | 1 | Only standby power present |
| kb_clk_in | input | 1 | Keyboard clock line |
| kb_dat_in | input | 1 | Keyboard data line |
| ms_clk_in | input | 1 | Mouse clock line |
| ms_dat_in | input | 1 | Mouse data line |
| kb_clk_ctl | output | 1 | Keyboard clock toward controller |
| kb_dat_ctl | output | 1 | Keyboard data toward controller |
| ms_clk_ctl | output | 1 | Mouse clock toward controller |
| ms_dat_ctl | output | 1 | Mouse data toward controller |
| kc_kb_irq | input | 1 | Raw keyboard interrupt from controller |
| kc_ms_irq | input | 1 | Raw mouse interrupt from controller |
| host_rd_kb | input | 1 | Host read strobe clearing the keyboard latch |
| host_rd_ms | input | 1 | Host read strobe clearing the mouse latch |
| kb_irq | output | 1 | Keyboard interrupt output |
| ms_irq | output | 1 | Mouse interrupt output |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| kc_rst | output | 1 | Holds the keyboard controller in reset |
| pme | output | 1 | Power-management wake event |

## Verification
The bench targets five corner cases.

- A data edge arriving while its line is isolated. A design that gated the wake path along with the controller path would never set the status bit.
- A clearing write in the same cycle as a new edge. If clear won, the wake would be lost.
- Interrupt pulses on standby power only, and data edges with neither supply indicator set. A missing supply qualifier would raise false status.
- A main reset with a write attempted during it. A design that tied the isolation bits to the main reset would drop the isolation.
- Both interrupt forms, including a host read strobe and a second raw rising edge. A swapped form would leave an interrupt stuck high or hide one.

// File: rtl/kbm_wake_iso.sv
module kbm_wake_iso #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_stby_n,
  input  logic       rst_main_n,
  input  logic       main_pwr,
  input  logic       stby_only,
  input  logic       kb_clk_in,
  input  logic       kb_dat_in,
  input  logic       ms_clk_in,
  input  logic       ms_dat_in,
  output logic       kb_clk_ctl,
  output logic       kb_dat_ctl,
  output logic       ms_clk_ctl,
  output logic       ms_dat_ctl,
  input  logic       kc_kb_irq,
  input  logic       kc_ms_irq,
  input  logic       host_rd_kb,
  input  logic       host_rd_ms,
  output logic       kb_irq,
  output logic       ms_irq,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       kc_rst,
  output logic       pme
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_GCFG = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_WEN  = 2'd3;
  localparam int TOP = SYNC_STAGES - 1;

  logic m_rst_n, wr_ok;
  logic iso_kb, iso_ms, sel_kb, sel_ms, kc_rst_q, gen;
  logic [4:0] stat, wen, stat_set, stat_clr;
  logic [SYNC_STAGES-1:0] kb_sy, ms_sy;
  logic kb_dp, ms_dp, kb_ip, ms_ip, kb_lat, ms_lat;
  logic kb_fall, ms_fall, kb_rise, ms_rise, edge_ok, irq_ok;

  assign m_rst_n = rst_stby_n & rst_main_n;
  assign wr_ok   = reg_wr & rst_main_n;

  assign kb_clk_ctl = iso_kb | kb_clk_in;
  assign kb_dat_ctl = iso_kb | kb_dat_in;
  assign ms_clk_ctl = iso_ms | ms_clk_in;
  assign ms_dat_ctl = iso_ms | ms_dat_in;

  assign kb_fall = kb_dp & ~kb_sy[TOP];
  assign ms_fall = ms_dp & ~ms_sy[TOP];
  assign kb_rise = kc_kb_irq & ~kb_ip;
  assign ms_rise = kc_ms_irq & ~ms_ip;
  assign edge_ok = main_pwr | stby_only;
  assign irq_ok  = main_pwr & rst_main_n;

  assign stat_set = {ms_fall & edge_ok, kb_fall & edge_ok, 1'b0,
                     ms_rise & irq_ok, kb_rise & irq_ok};
  assign stat_clr = (wr_ok && reg_addr == A_STAT) ?
                    {reg_wdata[4:3], 1'b0, reg_wdata[1:0]} : 5'd0;

  always_ff @(posedge clk or negedge rst_stby_n) begin
    if (!rst_stby_n) begin
      iso_kb <= 1'b0;
      iso_ms <= 1'b0;
      stat   <= '0;
      wen    <= '0;
      gen    <= 1'b0;
      kb_sy  <= '1;
      ms_sy  <= '1;
      kb_dp  <= 1'b1;
      ms_dp  <= 1'b1;
    end else begin
      kb_sy <= {kb_sy[SYNC_STAGES-2:0], kb_dat_in};
      ms_sy <= {ms_sy[SYNC_STAGES-2:0], ms_dat_in};
      kb_dp <= kb_sy[TOP];
      ms_dp <= ms_sy[TOP];
      stat  <= (stat & ~stat_clr) | stat_set;
      if (wr_ok && reg_addr == A_CTRL) begin
        iso_ms <= reg_wdata[6];
        iso_kb <= reg_wdata[5];
      end
      if (wr_ok && reg_addr == A_WEN) begin
        wen <= {reg_wdata[4:3], 1'b0, reg_wdata[1:0]};
        gen <= reg_wdata[7];
      end
    end
  end

  always_ff @(posedge clk or negedge m_rst_n) begin
    if (!m_rst_n) begin
      sel_kb   <= 1'b0;
      sel_ms   <= 1'b0;
      kc_rst_q <= 1'b0;
      kb_ip    <= 1'b0;
      ms_ip    <= 1'b0;
      kb_lat   <= 1'b0;
      ms_lat   <= 1'b0;
    end else begin
      kb_ip  <= kc_kb_irq;
      ms_ip  <= kc_ms_irq;
      kb_lat <= kb_rise | (kb_lat & ~host_rd_kb);
      ms_lat <= ms_rise | (ms_lat & ~host_rd_ms);
      if (wr_ok && reg_addr == A_CTRL) begin
        sel_ms <= reg_wdata[4];
        sel_kb <= reg_wdata[3];
      end
      if (wr_ok && reg_addr == A_GCFG) kc_rst_q <= reg_wdata[6];
    end
  end

  assign kb_irq = sel_kb ? kb_lat : (kc_kb_irq & kb_lat);
  assign ms_irq = sel_ms ? ms_lat : (kc_ms_irq & ms_lat);
  assign kc_rst = kc_rst_q;
  assign pme    = gen & (|(stat & wen));

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {1'b0, iso_ms, iso_kb, sel_ms, sel_kb, 3'b000};
      A_GCFG:  reg_rdata = {1'b0, kc_rst_q, 6'b000000};
      A_STAT:  reg_rdata = {3'b000, stat};
      default: reg_rdata = {gen, 2'b00, wen};
    endcase
  end

  // R1
  ms_iso_chk: assert property (@(posedge clk) disable iff (!rst_stby_n)
    iso_ms |-> (ms_clk_ctl && ms_dat_ctl));

  // R2
  kb_iso_chk: assert property (@(posedge clk) disable iff (!rst_stby_n)
    iso_kb |-> (kb_clk_ctl && kb_dat_ctl));

  // R6
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_stby_n)
    (stat[3] && !(wr_ok && reg_addr == A_STAT && reg_wdata[3])) |=> stat[3]);

  // R4
  irq_wake_main_chk: assert property (@(posedge clk) disable iff (!rst_stby_n)
    $rose(stat[0]) |-> $past(main_pwr));

  // R10
  iso_keep_chk: assert property (@(posedge clk) disable iff (!rst_stby_n)
    !rst_main_n |=> $stable({iso_ms, iso_kb}));

  // R9
  kb_lat_clr_chk: assert property (@(posedge clk) disable iff (!m_rst_n)
    (host_rd_kb && !kc_kb_irq) |=> !kb_irq);

  // R11
  kc_rst_hold_chk: assert property (@(posedge clk) disable iff (!m_rst_n)
    (kc_rst && !(wr_ok && reg_addr == A_GCFG)) |=> kc_rst);
endmodule

// File: tb/kbm_wake_iso_test.sv
module kbm_wake_iso_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_stby_n = 1'b0, rst_main_n = 1'b0, main_pwr = 1'b1, stby_only = 1'b0;
  logic kb_clk_in = 1'b1, kb_dat_in = 1'b1, ms_clk_in = 1'b1, ms_dat_in = 1'b1;
  logic kc_kb_irq = 1'b0, kc_ms_irq = 1'b0, host_rd_kb = 1'b0, host_rd_ms = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic kb_clk_ctl, kb_dat_ctl, ms_clk_ctl, ms_dat_ctl, kb_irq, ms_irq, kc_rst, pme;
  logic [7:0] reg_rdata;

  kbm_wake_iso #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_stby_n(rst_stby_n), .rst_main_n(rst_main_n),
    .main_pwr(main_pwr), .stby_only(stby_only),
    .kb_clk_in(kb_clk_in), .kb_dat_in(kb_dat_in), .ms_clk_in(ms_clk_in), .ms_dat_in(ms_dat_in),
    .kb_clk_ctl(kb_clk_ctl), .kb_dat_ctl(kb_dat_ctl), .ms_clk_ctl(ms_clk_ctl), .ms_dat_ctl(ms_dat_ctl),
    .kc_kb_irq(kc_kb_irq), .kc_ms_irq(kc_ms_irq), .host_rd_kb(host_rd_kb), .host_rd_ms(host_rd_ms),
    .kb_irq(kb_irq), .ms_irq(ms_irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .kc_rst(kc_rst), .pme(pme));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit m_iso_k, m_iso_m, m_sel_k, m_sel_m, m_kcr, m_gen;
  bit [4:0] m_stat, m_wen;
  bit m_qk[$], m_qm[$];
  bit m_pk, m_pm, m_ipk, m_ipm, m_lk, m_lm;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) begin
    bit wok, fk, fm, rk, rm, eok, iok;
    bit [4:0] setv, clrv;
    if (!rst_stby_n) begin
      m_iso_k = 0; m_iso_m = 0; m_stat = 0; m_wen = 0; m_gen = 0;
      m_qk = {}; m_qm = {};
      for (int i = 0; i < SYNC; i++) begin m_qk.push_back(1); m_qm.push_back(1); end
      m_pk = 1; m_pm = 1;
      m_sel_k = 0; m_sel_m = 0; m_kcr = 0; m_ipk = 0; m_ipm = 0; m_lk = 0; m_lm = 0;
    end else begin
      wok = reg_wr && rst_main_n;
      fk = m_pk && !m_qk[SYNC-1];
      fm = m_pm && !m_qm[SYNC-1];
      rk = kc_kb_irq && !m_ipk;
      rm = kc_ms_irq && !m_ipm;
      eok = main_pwr || stby_only;
      iok = main_pwr && rst_main_n;
      setv = 0;
      setv[0] = rk && iok; setv[1] = rm && iok;
      setv[3] = fk && eok; setv[4] = fm && eok;
      clrv = 0;
      if (wok && reg_addr == 2) begin
        clrv[0] = reg_wdata[0]; clrv[1] = reg_wdata[1];
        clrv[3] = reg_wdata[3]; clrv[4] = reg_wdata[4];
      end
      m_pk = m_qk[SYNC-1];
      m_pm = m_qm[SYNC-1];
      void'(m_qk.pop_back()); m_qk.push_front(kb_dat_in);
      void'(m_qm.pop_back()); m_qm.push_front(ms_dat_in);
      m_stat = (m_stat & ~clrv) | setv;
      if (wok && reg_addr == 0) begin m_iso_m = reg_wdata[6]; m_iso_k = reg_wdata[5]; end
      if (wok && reg_addr == 3) begin
        m_gen = reg_wdata[7];
        m_wen = 0; m_wen[0] = reg_wdata[0]; m_wen[1] = reg_wdata[1];
        m_wen[3] = reg_wdata[3]; m_wen[4] = reg_wdata[4];
      end
      if (!rst_main_n) begin
        m_sel_k = 0; m_sel_m = 0; m_kcr = 0; m_ipk = 0; m_ipm = 0; m_lk = 0; m_lm = 0;
      end else begin
        m_lk = rk ? 1 : (host_rd_kb ? 0 : m_lk);
        m_lm = rm ? 1 : (host_rd_ms ? 0 : m_lm);
        m_ipk = kc_kb_irq; m_ipm = kc_ms_irq;
        if (wok && reg_addr == 0) begin m_sel_m = reg_wdata[4]; m_sel_k = reg_wdata[3]; end
        if (wok && reg_addr == 1) m_kcr = reg_wdata[6];
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] er;
    chk("R2 kb_clk_ctl", {7'd0, kb_clk_ctl}, {7'd0, m_iso_k | kb_clk_in});
    chk("R2 kb_dat_ctl", {7'd0, kb_dat_ctl}, {7'd0, m_iso_k | kb_dat_in});
    chk("R1 ms_clk_ctl", {7'd0, ms_clk_ctl}, {7'd0, m_iso_m | ms_clk_in});
    chk("R1 ms_dat_ctl", {7'd0, ms_dat_ctl}, {7'd0, m_iso_m | ms_dat_in});
    chk("R8 kb_irq", {7'd0, kb_irq}, {7'd0, m_sel_k ? m_lk : (kc_kb_irq & m_lk)});
    chk("R8 ms_irq", {7'd0, ms_irq}, {7'd0, m_sel_m ? m_lm : (kc_ms_irq & m_lm)});
    chk("R7 pme", {7'd0, pme}, {7'd0, m_gen & (|(m_stat & m_wen))});
    chk("R11 kc_rst", {7'd0, kc_rst}, {7'd0, m_kcr});
    case (reg_addr)
      2'd0: er = {1'b0, m_iso_m, m_iso_k, m_sel_m, m_sel_k, 3'b000};
      2'd1: er = {1'b0, m_kcr, 6'd0};
      2'd2: er = {3'd0, m_stat};
      default: er = {m_gen, 2'b00, m_wen};
    endcase
    chk("R10 reg_rdata", reg_rdata, er);
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd_exp(string tag, logic [1:0] a, logic [7:0] mask, logic [7:0] exp);
    reg_addr = a;
    tick();
    chk(tag, reg_rdata & mask, exp);
  endtask

  initial begin
    tick(3);
    rst_stby_n = 1; rst_main_n = 1;
    tick();
    // R12 reset state
    for (int a = 0; a < 4; a++) rd_exp("R12 reg reset", a[1:0], 8'hff, 8'h00);
    chk("R12 pme reset", {7'd0, pme}, 8'd0);
    chk("R12 kb_irq reset", {7'd0, kb_irq}, 8'd0);
    // pass-through patterns
    kb_clk_in = 0; ms_dat_in = 0; tick();
    kb_clk_in = 1; kb_dat_in = 0; ms_dat_in = 1; ms_clk_in = 0; tick(4);
    kb_dat_in = 1; ms_clk_in = 1; tick(4);
    wr(3, 8'h00); wr(2, 8'h1b);
    // R2 / R1 isolation
    wr(0, 8'h20);
    kb_clk_in = 0; ms_clk_in = 0; tick();
    chk("R2 kb clk isolated", {7'd0, kb_clk_ctl}, 8'd1);
    chk("R1 ms clk passes", {7'd0, ms_clk_ctl}, 8'd0);
    kb_clk_in = 1; ms_clk_in = 1;
    wr(0, 8'h60);
    ms_clk_in = 0; tick();
    chk("R1 ms clk isolated", {7'd0, ms_clk_ctl}, 8'd1);
    ms_clk_in = 1;
    // R3 edges while isolated
    kb_dat_in = 0; tick(4); kb_dat_in = 1;
    rd_exp("R3 kb data edge isolated", 2, 8'h08, 8'h08);
    ms_dat_in = 0; tick(4); ms_dat_in = 1;
    rd_exp("R3 ms data edge isolated", 2, 8'h10, 8'h10);
    wr(2, 8'h18);
    rd_exp("R6 write one clears", 2, 8'hff, 8'h00);
    tick(3);
    // R6 set and clear in same cycle
    ms_dat_in = 0; tick(2);
    wr(2, 8'h10);
    rd_exp("R6 set wins over clear", 2, 8'h10, 8'h10);
    ms_dat_in = 1; wr(2, 8'h1b); tick(4);
    // R4 interrupt wake needs main power
    kc_kb_irq = 1; tick(); kc_kb_irq = 0; tick();
    rd_exp("R4 kb irq wake main", 2, 8'h01, 8'h01);
    wr(2, 8'h1b);
    main_pwr = 0; stby_only = 1;
    kc_kb_irq = 1; kc_ms_irq = 1; tick(); kc_kb_irq = 0; kc_ms_irq = 0; tick();
    rd_exp("R4 no irq wake on standby", 2, 8'h03, 8'h00);
    kb_dat_in = 0; tick(4); kb_dat_in = 1;
    rd_exp("R5 data edge on standby", 2, 8'h08, 8'h08);
    wr(2, 8'h1b); tick(3);
    stby_only = 0;
    ms_dat_in = 0; tick(4); ms_dat_in = 1;
    rd_exp("R5 no edge without supply", 2, 8'h10, 8'h00);
    main_pwr = 1; tick(3);
    // R7 wake output gating
    kb_dat_in = 0; tick(4); kb_dat_in = 1;
    wr(3, 8'h08); tick();
    chk("R7 no global enable", {7'd0, pme}, 8'd0);
    wr(3, 8'h88); tick();
    chk("R7 all enables", {7'd0, pme}, 8'd1);
    wr(3, 8'h90); tick();
    chk("R7 wrong source enabled", {7'd0, pme}, 8'd0);
    wr(3, 8'h88); wr(2, 8'h08); tick();
    chk("R7 status cleared", {7'd0, pme}, 8'd0);
    // R8 / R9 gated form (select 0)
    kc_kb_irq = 1; tick(2);
    chk("R8 gated form high", {7'd0, kb_irq}, 8'd1);
    kc_kb_irq = 0; tick();
    chk("R8 gated form follows raw", {7'd0, kb_irq}, 8'd0);
    kc_kb_irq = 1; host_rd_kb = 1; tick(); host_rd_kb = 0; tick();
    chk("R9 set wins over read", {7'd0, kb_irq}, 8'd1);
    host_rd_kb = 1; tick(); host_rd_kb = 0; tick();
    chk("R9 read clears latch", {7'd0, kb_irq}, 8'd0);
    kc_kb_irq = 0; tick();
    // latched form
    wr(0, 8'h78);
    kc_kb_irq = 1; kc_ms_irq = 1; tick(); kc_kb_irq = 0; kc_ms_irq = 0; tick(2);
    chk("R8 kb latched form", {7'd0, kb_irq}, 8'd1);
    chk("R8 ms latched form", {7'd0, ms_irq}, 8'd1);
    host_rd_kb = 1; host_rd_ms = 1; tick(); host_rd_kb = 0; host_rd_ms = 0; tick();
    chk("R9 kb read clears", {7'd0, kb_irq}, 8'd0);
    chk("R9 ms read clears", {7'd0, ms_irq}, 8'd0);
    // R11 controller reset bit
    wr(1, 8'h40); tick(5);
    chk("R11 kc_rst held", {7'd0, kc_rst}, 8'd1);
    wr(1, 8'h00); tick();
    chk("R11 kc_rst cleared", {7'd0, kc_rst}, 8'd0);
    wr(1, 8'h40);
    // R10 main reset keeps isolation
    rst_main_n = 0; tick();
    wr(0, 8'h00); wr(3, 8'h00);
    rst_main_n = 1; tick();
    rd_exp("R10 isolation kept, select cleared", 0, 8'hff, 8'h60);
    rd_exp("R10 enables kept", 3, 8'hff, 8'h88);
    chk("R10 kc_rst cleared by main reset", {7'd0, kc_rst}, 8'd0);
    rst_stby_n = 0; tick(); rst_stby_n = 1; tick();
    rd_exp("R10 standby reset clears isolation", 0, 8'hff, 8'h00);
    tick(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule